// File: doc/BRIEF.md
# Interrupt Request Raise and Acknowledge Sequencer

This block sits between a priority selector and the processor's two interrupt inputs: a normal request and a fast request. The selector presents, for each class, a flag that some enabled source is pending and the code of the winning line. When a class is idle and a global enable permits, the block raises that class's request and freezes the winning code. It then holds both until software acknowledges the class through a control register. Acknowledging drops the request and returns the class to idle, so the next winner is taken on the following cycle.

Software reads the frozen code through one source-code register per class. Such a read also emits a one-cycle clear strobe that carries the code to the pending-capture logic. That logic drops the line if it is edge-configured. Registers are decoded in bank 0 only: offset 0x10 holds the normal source code, 0x14 the fast source code and 0x18 the acknowledge control. The bank number is taken from address bits 8 and up.

Top module: `intr_ack_seq`

## Requirements
- R1: After reset both request outputs are 0, both source codes are 0 and both classes are idle, so a candidate present with the enable high raises its request on the first clock edge after reset is released.
- R2: When a class is idle, its candidate flag is 1 and the enable is 1 at a clock edge, that edge sets the class's request to 1 and loads its source code with the winner code.
- R3: While the enable is 0, no request rises. A request that is already high stays high.
- R4: While a request is high and no acknowledge is written for it, the request stays 1 and the source code stays unchanged, whatever the winner code and candidate flag do.
- R5: A write to bank 0 offset 0x18 with data bit 0 set drops the normal request at that edge. Data bit 1 does the same for the fast request. If a candidate is still present with the enable high at the next edge, the request rises again with the current winner code.
- R6: The two classes are independent. An acknowledge of one class leaves the other's request and code unchanged.
- R7: A read of bank 0 offset 0x10 returns the normal source code, zero-extended on read data in the same cycle. Offset 0x14 does the same for the fast source code.
- R8: A read of offset 0x10 or 0x14 in bank 0 sets the clear strobe in that cycle, with the read code on the clear-line output. No other access sets the strobe.
- R9: A read of offset 0x18 returns 0. Reads and acknowledge writes aimed at any bank other than 0 return 0, do not strobe and do not change any request.
- R10: Writes to offsets 0x10 and 0x14 change neither a request nor a source code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nrm_any_i | input | 1 | A normal-class candidate is pending |
| nrm_code_i | input | CODE_W | Winning normal-class line code |
| fst_any_i | input | 1 | A fast-class candidate is pending |
| fst_code_i | input | CODE_W | Winning fast-class line code |
| glb_en_i | input | 1 | Global permission to raise requests |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address; bits 8 and up select the bank |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid while rd_i is high |
| nrm_req_o | output | 1 | Normal interrupt request |
| fst_req_o | output | 1 | Fast interrupt request |
| nrm_src_o | output | CODE_W | Frozen normal-class source code |
| fst_src_o | output | CODE_W | Frozen fast-class source code |
| clr_o | output | 1 | Clear strobe toward the pending logic |
| clr_line_o | output | CODE_W | Line code to clear when clr_o is high |

## Verification
The only internal state is each class's request flop and its frozen code. An idle state that should be busy shows at once as a request that fails to rise, or as a frozen code that follows the winner one edge later. A busy state that fails to re-arm shows as a request that stays low on the second edge after an acknowledge. Acknowledges steered to the wrong class, or decoded from a bank other than 0, show within one edge on the other class's request. A wrong read mux or strobe shows in the same cycle as the read.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
  localparam int unsigned NUM_CLS = 2;
  localparam logic [7:0] OFF_SRC_NRM = 8'h10;
  localparam logic [7:0] OFF_SRC_FST = 8'h14;
  localparam logic [7:0] OFF_ACK     = 8'h18;

  typedef enum logic {
    CLS_NRM = 1'b0,
    CLS_FST = 1'b1
  } cls_e;
endpackage

// File: rtl/intr_seq_class.sv
module intr_seq_class #(
  parameter int unsigned CODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cand_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              en_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [CODE_W-1:0] src_o
);
  logic              req_q;
  logic [CODE_W-1:0] src_q;
  logic              armed;
  logic              fire;

  // idle and busy are exact complements: one flop holds both
  assign armed = ~req_q;
  assign fire  = armed & cand_i & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      src_q <= '0;
    end else if (ack_i) begin
      req_q <= 1'b0;
    end else if (fire) begin
      req_q <= 1'b1;
      src_q <= code_i;
    end
  end

  assign req_o = req_q;
  assign src_o = src_q;

  AST_RAISE_NEEDS_CAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(cand_i && en_i)); // R2
  AST_SRC_MOVES_ON_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(src_o) |-> $rose(req_o)); // R2
  AST_NO_RAISE_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !req_o) |=> !req_o); // R3
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (req_o && $stable(src_o))); // R4
  AST_ACK_DROPS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !req_o); // R5
endmodule

// File: rtl/intr_seq_regs.sv
module intr_seq_regs
  import intr_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CODE_W-1:0] src_nrm_i,
  input  logic [CODE_W-1:0] src_fst_i,
  output logic [NUM_CLS-1:0] ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              clr_o,
  output logic [CODE_W-1:0] clr_line_o
);
  localparam int unsigned BANK_W = ADDR_W - 8;

  logic [BANK_W-1:0] bank;
  logic [7:0]        offs;
  logic              bank0;
  logic              hit_nrm, hit_fst, hit_ack;
  logic              unused_wdata;

  assign bank    = addr_i[ADDR_W-1:8];
  assign offs    = addr_i[7:0];
  assign bank0   = (bank == '0);
  assign hit_nrm = bank0 && (offs == OFF_SRC_NRM);
  assign hit_fst = bank0 && (offs == OFF_SRC_FST);
  assign hit_ack = bank0 && (offs == OFF_ACK);
  assign unused_wdata = ^wdata_i[DATA_W-1:NUM_CLS];

  // ack bit index equals class encoding
  for (genvar c = 0; c < NUM_CLS; c++) begin : g_ack
    assign ack_o[c] = wr_i && hit_ack && wdata_i[c];
  end

  always_comb begin
    rdata_o    = '0;
    clr_o      = 1'b0;
    clr_line_o = src_nrm_i;
    if (rd_i) begin
      if (hit_nrm) begin
        rdata_o    = DATA_W'(src_nrm_i);
        clr_o      = 1'b1;
        clr_line_o = src_nrm_i;
      end else if (hit_fst) begin
        rdata_o    = DATA_W'(src_fst_i);
        clr_o      = 1'b1;
        clr_line_o = src_fst_i;
      end
    end
  end

  AST_CLR_ONLY_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |-> (rd_i && addr_i[ADDR_W-1:8] == '0)); // R8
  AST_ACK_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ack_o) |-> (wr_i && addr_i[ADDR_W-1:8] == '0)); // R9
endmodule

// File: rtl/intr_ack_seq.sv
module intr_ack_seq
  import intr_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nrm_any_i,
  input  logic [CODE_W-1:0] nrm_code_i,
  input  logic              fst_any_i,
  input  logic [CODE_W-1:0] fst_code_i,
  input  logic              glb_en_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              nrm_req_o,
  output logic              fst_req_o,
  output logic [CODE_W-1:0] nrm_src_o,
  output logic [CODE_W-1:0] fst_src_o,
  output logic              clr_o,
  output logic [CODE_W-1:0] clr_line_o
);
  logic [NUM_CLS-1:0]             cand;
  logic [NUM_CLS-1:0][CODE_W-1:0] code;
  logic [NUM_CLS-1:0]             ack;
  logic [NUM_CLS-1:0]             req;
  logic [NUM_CLS-1:0][CODE_W-1:0] src;

  assign cand[CLS_NRM] = nrm_any_i;
  assign cand[CLS_FST] = fst_any_i;
  assign code[CLS_NRM] = nrm_code_i;
  assign code[CLS_FST] = fst_code_i;

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    intr_seq_class #(.CODE_W(CODE_W)) u_cls (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cand_i (cand[c]),
      .code_i (code[c]),
      .en_i   (glb_en_i),
      .ack_i  (ack[c]),
      .req_o  (req[c]),
      .src_o  (src[c])
    );
  end

  intr_seq_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CODE_W (CODE_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .src_nrm_i  (src[CLS_NRM]),
    .src_fst_i  (src[CLS_FST]),
    .ack_o      (ack),
    .rdata_o    (rdata_o),
    .clr_o      (clr_o),
    .clr_line_o (clr_line_o)
  );

  assign nrm_req_o = req[CLS_NRM];
  assign fst_req_o = req[CLS_FST];
  assign nrm_src_o = src[CLS_NRM];
  assign fst_src_o = src[CLS_FST];

  AST_CLASSES_APART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack == 2'b01 && fst_req_o) |=> (fst_req_o && $stable(fst_src_o))); // R6
endmodule

// File: tb/tb_intr_ack_seq.sv
module tb_intr_ack_seq;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CODE_W = 5;
  localparam int unsigned NCODE  = 1 << CODE_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              nrm_any = 1'b0, fst_any = 1'b0, glb_en = 1'b0;
  logic [CODE_W-1:0] nrm_code = '0, fst_code = '0;
  logic              wr = 1'b0, rd = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              nrm_req, fst_req, clr;
  logic [CODE_W-1:0] nrm_src, fst_src, clr_line;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  intr_ack_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .nrm_any_i(nrm_any), .nrm_code_i(nrm_code),
    .fst_any_i(fst_any), .fst_code_i(fst_code),
    .glb_en_i(glb_en), .wr_i(wr), .rd_i(rd), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .nrm_req_o(nrm_req), .fst_req_o(fst_req),
    .nrm_src_o(nrm_src), .fst_src_o(fst_src),
    .clr_o(clr), .clr_line_o(clr_line)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    wr = 1'b1; addr = a; wdata = d;
    tick();
    wr = 1'b0; addr = '0; wdata = '0;
  endtask

  // combinational read: checked in the same cycle
  task automatic reg_rd(input logic [ADDR_W-1:0] a, input string req,
                        input longint exp_data, input bit exp_clr);
    rd = 1'b1; addr = a;
    #1;
    chk(req, rdata, exp_data);
    chk(req, clr, exp_clr);
    if (exp_clr) chk(req, clr_line, exp_data);
    tick();
    rd = 1'b0; addr = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset values
    repeat (3) @(negedge clk);
    chk("R1 nrm_req", nrm_req, 0);
    chk("R1 fst_req", fst_req, 0);
    chk("R1 nrm_src", nrm_src, 0);
    chk("R1 fst_src", fst_src, 0);
    nrm_any = 1'b1; nrm_code = 5'd9; glb_en = 1'b1;
    rst_n = 1'b1;
    tick();
    chk("R1 armed from reset", nrm_req, 1);
    chk("R1 armed code", nrm_src, 9);
    reg_wr(10'h018, 32'h1);
    nrm_any = 1'b0;
    tick();
    chk("R5 no candidate stays low", nrm_req, 0);

    // R3 enable gating
    glb_en = 1'b0; nrm_any = 1'b1; nrm_code = 5'd7;
    fst_any = 1'b1; fst_code = 5'd3;
    repeat (3) tick();
    chk("R3 nrm blocked", nrm_req, 0);
    chk("R3 fst blocked", fst_req, 0);
    glb_en = 1'b1;
    tick();
    chk("R2 nrm raise", nrm_req, 1);
    chk("R2 nrm code", nrm_src, 7);
    chk("R2 fst raise", fst_req, 1);
    chk("R2 fst code", fst_src, 3);
    glb_en = 1'b0;
    tick();
    chk("R3 high stays high", nrm_req, 1);
    glb_en = 1'b1;

    // R4 hold while busy
    nrm_code = 5'd20; fst_code = 5'd0;
    repeat (2) tick();
    chk("R4 nrm req held", nrm_req, 1);
    chk("R4 nrm code held", nrm_src, 7);
    chk("R4 fst code held", fst_src, 3);
    nrm_any = 1'b0;
    tick();
    chk("R4 held without candidate", nrm_req, 1);
    nrm_any = 1'b1;

    // R7 R8 reads
    reg_rd(10'h010, "R7 R8 nrm read", 7, 1'b1);
    reg_rd(10'h014, "R7 R8 fst read", 3, 1'b1);
    // R9 other offsets and banks
    reg_rd(10'h018, "R9 ack reads zero", 0, 1'b0);
    reg_rd(10'h110, "R9 bank1 nrm", 0, 1'b0);
    reg_rd(10'h214, "R9 bank2 fst", 0, 1'b0);
    reg_rd(10'h000, "R8 other offset", 0, 1'b0);
    reg_wr(10'h118, 32'h3);
    chk("R9 bank1 ack nrm", nrm_req, 1);
    chk("R9 bank1 ack fst", fst_req, 1);

    // R10 writes to source registers
    reg_wr(10'h010, 32'h1f);
    reg_wr(10'h014, 32'h1f);
    chk("R10 nrm req", nrm_req, 1);
    chk("R10 nrm src", nrm_src, 7);
    chk("R10 fst req", fst_req, 1);
    chk("R10 fst src", fst_src, 3);

    // sweep all codes through both classes
    for (int c = 0; c < NCODE; c++) begin
      nrm_code = CODE_W'(c);
      fst_code = CODE_W'(NCODE - 1 - c);
      reg_wr(10'h018, 32'h1);
      chk("R5 nrm dropped", nrm_req, 0);
      chk("R6 fst untouched", fst_req, 1);
      tick();
      chk("R5 nrm re-raised", nrm_req, 1);
      chk("R5 nrm new code", nrm_src, c);
      reg_wr(10'h018, 32'h2);
      chk("R5 fst dropped", fst_req, 0);
      chk("R6 nrm untouched", nrm_req, 1);
      chk("R6 nrm code kept", nrm_src, c);
      tick();
      chk("R5 fst re-raised", fst_req, 1);
      chk("R5 fst new code", fst_src, NCODE - 1 - c);
      reg_rd(10'h010, "R7 sweep nrm", c, 1'b1);
      reg_rd(10'h014, "R7 sweep fst", NCODE - 1 - c, 1'b1);
    end

    // both at once, then no candidates
    nrm_any = 1'b0; fst_any = 1'b0;
    reg_wr(10'h018, 32'h3);
    chk("R5 both dropped nrm", nrm_req, 0);
    chk("R5 both dropped fst", fst_req, 0);
    tick();
    chk("R5 idle nrm", nrm_req, 0);
    chk("R5 idle fst", fst_req, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule